// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Down-Counter

This block raises a cartridge interrupt after a programmed number of CPU cycles, measured in coarse steps. Software loads a 16-bit count one byte at a time through two write ports. It then sets an arming bit in a control byte. An external scanline tick, produced elsewhere, arrives once per display line. Each tick removes a fixed 113-cycle quantum from the count.

When a tick finds the count at or below one quantum, the count snaps to zero and an interrupt request goes high. The request is a level and stays high until software writes the control byte again or the block is reset. While the count rests at zero and the block stays armed, every later tick raises the request again. Software therefore has to disarm the block or reload the count to stop repeated interrupts.

A count V fires on tick number max(1, ceil(V / 113)).

Top module: `scanline_irq_timer`

## Requirements
- R1: A write to address 0xF000 replaces bits 7:0 of the count with the data byte and leaves bits 15:8 unchanged.
- R2: A write to address 0xF004 replaces bits 15:8 of the count with the data byte and leaves bits 7:0 unchanged.
- R3: A write to address 0xF008 stores the whole data byte as the control byte and drops the interrupt request on the following cycle.
- R4: Ticks are acted on only while bit 1 of the control byte is 1 (for example 0x02). With that bit at 0 (for example 0xFD), a tick changes neither the count nor the interrupt request.
- R5: An armed tick that finds the count at 113 or less forces the count to 0 and raises the interrupt request one cycle after the tick.
- R6: An armed tick that finds the count above 113 reduces it by 113. A loaded value V therefore fires on tick max(1, ceil(V/113)): 0 and 113 fire on tick 1, 114 and 226 on tick 2, 227 on tick 3, 768 on tick 7, and 0xFFFF on tick 580.
- R7: Reset clears the count, the control byte and the interrupt request.
- R8: Once raised, the interrupt request stays high through ticks and through other writes. Only a control-byte write or a reset lowers it.
- R9: A tick that arrives in the same cycle as a write to any of the three block addresses is discarded.
- R10: While armed with the count at 0, each tick raises the interrupt request again.
- R11: Writes to any other address, such as 0xF001 or 0xF00C, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq | output | 1 | Interrupt request, active high, sticky |

## Verification
All state sits in one register stage. The effect of a write or of a tick therefore appears exactly one clock after the edge that samples it. The bench drives every stimulus on a falling edge and reads `irq` on the next falling edge, one full edge after the register updates.

The count has no port of its own, so the bench observes it through firing times. It counts the ticks up to the first rise of `irq` and compares that count with max(1, ceil(V/113)). Writes that must be ignored, and ticks that must be discarded, are judged the same way: by whether the firing tick moves.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned CNT_W  = 2 * DATA_W;
    localparam int unsigned ADDR_W = 16;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_CTL
    } sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] ctl;
        logic              irq;
    } state_t;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR  = 16'hF000,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 16'hF004,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hF008
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output sel_e              sel
);
    always_comb begin
        sel = SEL_NONE;
        if (wr_en) begin
            if (wr_addr == LO_ADDR)
                sel = SEL_LO;
            else if (wr_addr == HI_ADDR)
                sel = SEL_HI;
            else if (wr_addr == CTL_ADDR)
                sel = SEL_CTL;
        end
    end
endmodule

// File: rtl/sirq_step.sv
module sirq_step
    import sirq_pkg::*;
#(
    parameter int unsigned STEP = 113
) (
    input  logic [CNT_W-1:0] cnt_in,
    output logic             fire,
    output logic [CNT_W-1:0] cnt_out
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    always_comb begin
        fire    = (cnt_in <= STEP_V);
        cnt_out = fire ? '0 : (cnt_in - STEP_V);
    end
endmodule

// File: rtl/sirq_core.sv
module sirq_core
    import sirq_pkg::*;
#(
    parameter int unsigned STEP   = 113,
    parameter int unsigned EN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_tick,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic [DATA_W-1:0] ctl_q_o,
    output logic              irq_q_o
);
    state_t           st_d, st_q;
    logic             step_fire;
    logic [CNT_W-1:0] step_cnt;

    sirq_step #(.STEP(STEP)) u_step (
        .cnt_in (st_q.cnt),
        .fire   (step_fire),
        .cnt_out(step_cnt)
    );

    always_comb begin
        st_d = st_q;
        unique case (sel)
            SEL_LO:  st_d.cnt[DATA_W-1:0]     = wr_data;
            SEL_HI:  st_d.cnt[CNT_W-1:DATA_W] = wr_data;
            SEL_CTL: begin
                st_d.ctl = wr_data;
                st_d.irq = 1'b0;
            end
            default: begin
                if (line_tick && st_q.ctl[EN_BIT]) begin
                    st_d.cnt = step_cnt;
                    if (step_fire)
                        st_d.irq = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_q_o = st_q.cnt;
    assign ctl_q_o = st_q.ctl;
    assign irq_q_o = st_q.irq;
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
    import sirq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR  = 16'hF000,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 16'hF004,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hF008,
    parameter int unsigned       STEP     = 113,
    parameter int unsigned       EN_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_tick,
    output logic              irq
);
    sel_e              sel_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] ctl_w;

    sirq_decode #(
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR),
        .CTL_ADDR(CTL_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .sel    (sel_w)
    );

    sirq_core #(
        .STEP  (STEP),
        .EN_BIT(EN_BIT)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel_w),
        .wr_data  (wr_data),
        .line_tick(line_tick),
        .cnt_q_o  (cnt_w),
        .ctl_q_o  (ctl_w),
        .irq_q_o  (irq)
    );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk
    import sirq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR  = 16'hF000,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 16'hF004,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hF008,
    parameter int unsigned       STEP     = 113,
    parameter int unsigned       EN_BIT   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              line_tick,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] ctl
);
    logic wr_lo, wr_hi, wr_ctl, wr_any, armed_tick;
    assign wr_lo      = wr_en && (wr_addr == LO_ADDR);
    assign wr_hi      = wr_en && (wr_addr == HI_ADDR);
    assign wr_ctl     = wr_en && (wr_addr == CTL_ADDR);
    assign wr_any     = wr_lo || wr_hi || wr_ctl;
    assign armed_tick = line_tick && !wr_any && ctl[EN_BIT];

    // R1
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (cnt[DATA_W-1:0] == $past(wr_data)) &&
                  (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W])));

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (cnt[CNT_W-1:DATA_W] == $past(wr_data)) &&
                  (cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0])));

    // R3
    ctl_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> !irq && (ctl == $past(wr_data)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !wr_any && !ctl[EN_BIT]) |=> $stable(cnt) && $stable(irq));

    // R5
    fire_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_tick && (cnt <= CNT_W'(STEP))) |=> (cnt == '0) && irq);

    // R6
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_tick && (cnt > CNT_W'(STEP))) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(STEP))));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctl) |=> irq);

    // R9
    rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(line_tick && !wr_any));
endmodule

bind scanline_irq_timer sirq_chk #(
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR),
    .CTL_ADDR(CTL_ADDR),
    .STEP    (STEP),
    .EN_BIT  (EN_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .line_tick(line_tick),
    .irq      (irq),
    .cnt      (cnt_w),
    .ctl      (ctl_w)
);

// File: tb/scanline_irq_timer_test.sv
module scanline_irq_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scanline_irq_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_tick(line_tick), .irq(irq)
    );

    // {loaded count, expected firing tick}
    localparam logic [31:0] VEC [8] = '{
        {16'd0,     16'd1},
        {16'd113,   16'd1},
        {16'd114,   16'd2},
        {16'd1,     16'd1},
        {16'd226,   16'd2},
        {16'd227,   16'd3},
        {16'd768,   16'd7},
        {16'hFFFF,  16'd580}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, bit with_tick = 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; line_tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; line_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    task automatic load(logic [15:0] v);
        wr(16'hF000, v[7:0]);
        wr(16'hF004, v[15:8]);
    endtask

    task automatic ticks_to_fire(output int n);
        n = 0;
        for (int i = 1; i <= 700; i++) begin
            tick();
            if (irq) begin
                n = i;
                break;
            end
        end
    endtask

    int n;

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: reset state
        check("R7 irq after reset", int'(irq), 0);

        // R5 R6: firing tick for each loaded value
        foreach (VEC[k]) begin
            wr(16'hF008, 8'h00);
            load(VEC[k][31:16]);
            wr(16'hF008, 8'h02);
            check("R6 no irq before ticks", int'(irq), 0);
            ticks_to_fire(n);
            check($sformatf("R5 R6 fire tick for %0d", VEC[k][31:16]), n, int'(VEC[k][15:0]));
        end

        // R8: sticky through ticks and other writes
        tick(); tick();
        wr(16'hF000, 8'h55);
        check("R8 irq held", int'(irq), 1);
        // R3: control write acknowledges
        wr(16'hF008, 8'h02);
        check("R3 irq cleared by control write", int'(irq), 0);

        // R10: count at zero refires
        wr(16'hF008, 8'h00);
        load(16'd0);
        wr(16'hF008, 8'h02);
        tick();
        check("R10 first fire at zero", int'(irq), 1);
        wr(16'hF008, 8'h02);
        tick();
        check("R10 refire at zero", int'(irq), 1);

        // R1 R2: byte lanes kept
        wr(16'hF008, 8'h00);
        load(16'd226);
        wr(16'hF004, 8'h01);          // count 0x01E2 = 482
        wr(16'hF008, 8'h02);
        ticks_to_fire(n);
        check("R2 high byte write keeps low byte", n, 5);
        wr(16'hF008, 8'h00);
        load(16'h01E2);
        wr(16'hF000, 8'h05);          // count 0x0105 = 261
        wr(16'hF008, 8'h02);
        ticks_to_fire(n);
        check("R1 low byte write keeps high byte", n, 3);

        // R4: disarmed ticks change nothing
        wr(16'hF008, 8'h00);
        load(16'd200);
        wr(16'hF008, 8'hFD);
        tick(); tick(); tick();
        check("R4 no irq while disarmed", int'(irq), 0);
        wr(16'hF008, 8'h02);
        ticks_to_fire(n);
        check("R4 count untouched while disarmed", n, 2);

        // R11: foreign addresses ignored
        wr(16'hF008, 8'h00);
        load(16'd114);
        wr(16'hF001, 8'h00);
        wr(16'hF00C, 8'h00);
        wr(16'hF008, 8'h02);
        ticks_to_fire(n);
        check("R11 stray writes ignored", n, 2);

        // R9: tick coinciding with a count write is discarded
        wr(16'hF008, 8'h00);
        load(16'd0);
        wr(16'hF008, 8'h02);
        wr(16'hF000, 8'h72, 1);       // count 114, tick dropped
        check("R9 no fire on collision", int'(irq), 0);
        ticks_to_fire(n);
        check("R9 count from write, not stepped", n, 2);

        // R7: reset mid-run clears count, control and irq
        wr(16'hF008, 8'h00);
        load(16'd500);
        wr(16'hF008, 8'h02);
        tick();
        do_reset();
        check("R7 irq cleared by reset", int'(irq), 0);
        tick();
        check("R7 control cleared by reset", int'(irq), 0);
        wr(16'hF008, 8'h02);
        ticks_to_fire(n);
        check("R7 count cleared by reset", n, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule